// File: doc/BRIEF.md
# Nibble-Serial Bus Memory Responder

This block sits on the memory side of a 4-bit serial bus on which a processor sends a command, then an address one nibble at a time, then expects data back one nibble per cycle. The responder keeps two private 20-bit pointers of its own: one for data accesses and one for instruction fetch. A load command picks which pointer the next five address nibbles fill. Once the fifth nibble has arrived, the responder moves into reading by itself. It spends one idle cycle fetching the first nibble from a 256-nibble synchronous memory, and after that it drives one nibble per cycle onto the bus.

The bus is locked to the clock and has no back-pressure. Every cycle carries exactly one command or nibble, and the responder must have data ready in the cycle it drives it. For that reason the data path has no valid/ready handshake. The only qualifier on the outgoing nibble is the drive enable, and the bus owner must accept the nibble in that cycle. The memory side is a plain synchronous read port: the read data for an address requested in one cycle is expected in the next cycle.

Top module: `nbus_mem_ctrl`

## Requirements
- R1: `bus_cmd` is decoded every clock cycle. The codes are 2'b00 = idle, 2'b01 = load data pointer, 2'b10 = load fetch pointer and 2'b11 = reserved. After a load command, the `bus_nib_in` values of the next five cycles fill the selected 20-bit pointer, least significant nibble first.
- R2: The cycle after the fifth address nibble is a dummy cycle in which `bus_drive_en` is low. Read data starts in the cycle after the dummy cycle.
- R3: `bus_drive_en` is high only in read data cycles, never in a command, address or dummy cycle. Whenever it is low, `bus_nib_out` is 4'h0.
- R4: If a read starts at address A, its i-th data nibble (counting from 0) is memory[(A+i) mod 2^20, low 8 bits]. The pointer advances by one after each driven nibble and wraps modulo 2^20.
- R5: A read through the data pointer ends after 16 nibbles. `bus_drive_en` and `ram_rd_en` then stay low until the next load command.
- R6: A read through the fetch pointer keeps driving one nibble per cycle for as long as no load command arrives, with no limit on its length.
- R7: A load command in any cycle (address, dummy or read) abandons the access in progress and starts a new address capture. In that cycle `bus_drive_en` and `ram_rd_en` are low.
- R8: The reserved code 2'b11 has no effect. In an address cycle the nibble is still captured. In a read cycle the data stream continues. In idle nothing is driven.
- R9: The memory port is read with `ram_rd_en` and `ram_addr`, and `ram_rdata` is taken to be valid one cycle later. In the dummy cycle the port reads the low 8 bits of the newly loaded address.
- R10: After reset the block is idle, with `bus_drive_en`, `ram_rd_en` and `bus_nib_out` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cmd | input | 2 | Bus command code for this cycle |
| bus_nib_in | input | 4 | Address nibble driven by the bus owner |
| bus_nib_out | output | 4 | Data nibble driven by the responder |
| bus_drive_en | output | 1 | High when `bus_nib_out` carries read data |
| ram_rd_en | output | 1 | Memory read request |
| ram_addr | output | 8 | Memory nibble address |
| ram_rdata | input | 4 | Memory read data, one cycle after the request |

## Verification
The hardest situation to reach is a command that arrives in the middle of a phase: a load that lands in the middle of the address nibbles, in the dummy cycle, or a few nibbles into a read, and a reserved code placed among the address nibbles. The bench builds each of these from cycle-level tasks that issue one command or nibble per cycle. This lets a scenario break into any phase at an exact cycle and then confirm that the next access reads from the new address. Wrap-around is reached by loading the fetch pointer just below 2^20 and streaming past the top of the address space.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_LD_DP = 2'b01,
    CMD_LD_PC = 2'b10,
    CMD_RSVD  = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DUMMY = 2'd2,
    ST_READ  = 2'd3
  } ctl_state_e;

  typedef enum logic {
    SEL_DP = 1'b0,
    SEL_PC = 1'b1
  } ptr_sel_e;

  function automatic logic cmd_is_load(bus_cmd_e c);
    return (c == CMD_LD_DP) || (c == CMD_LD_PC);
  endfunction

endpackage

// File: rtl/nbus_cmd_fsm.sv
module nbus_cmd_fsm
  import nbus_pkg::*;
#(
  parameter int ADDR_NIBS = 5,
  parameter int WORD_NIBS = 16,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_cmd_e         cmd,
  output ctl_state_e       state_q,
  output ptr_sel_e         sel_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             load_now
);

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_NIBS - 1);

  ctl_state_e       state_d;
  ptr_sel_e         sel_d;
  logic [CNT_W-1:0] cnt_d;

  assign load_now = cmd_is_load(cmd);

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    cnt_d   = cnt_q;
    if (load_now) begin
      state_d = ST_ADDR;
      sel_d   = (cmd == CMD_LD_PC) ? SEL_PC : SEL_DP;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
        end
        ST_ADDR: begin
          if (cnt_q == ADDR_LAST) begin
            state_d = ST_DUMMY;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          state_d = ST_READ;
          cnt_d   = '0;
        end
        ST_READ: begin
          if (sel_q == SEL_DP) begin
            if (cnt_q == WORD_LAST) begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= SEL_DP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      cnt_q   <= cnt_d;
    end
  end

  // R7: any load restarts address capture
  p_load_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (state_q == ST_ADDR) && (cnt_q == '0));

  // R2: fifth address nibble leads into the dummy cycle, then data
  p_addr_to_dummy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && cnt_q == ADDR_LAST && !load_now) |=> state_q == ST_DUMMY);

  p_dummy_to_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DUMMY && !load_now) |=> state_q == ST_READ);

  // R5: a data-pointer word ends after its last nibble
  p_dp_word_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && sel_q == SEL_DP && cnt_q == WORD_LAST && !load_now)
      |=> state_q == ST_IDLE);

  // R6: a fetch-pointer stream has no end of its own
  p_pc_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && sel_q == SEL_PC && !load_now) |=> state_q == ST_READ);

  // R8: reserved code leaves an idle block idle
  p_rsvd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cmd == CMD_RSVD) |=> state_q == ST_IDLE);

endmodule

// File: rtl/nbus_ptr_reg.sv
module nbus_ptr_reg #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 5,
  parameter int IDX_W     = 4,
  parameter int MEM_AW    = 8,
  parameter int PTR_W     = NIB_W * ADDR_NIBS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [NIB_W-1:0]  cap_nib,
  input  logic              inc_en,
  output logic [MEM_AW-1:0] ptr_lo
);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (cap_en) begin
      for (int n = 0; n < ADDR_NIBS; n++) begin
        if (cap_idx == IDX_W'(n)) ptr_q[n*NIB_W +: NIB_W] <= cap_nib;
      end
    end else if (inc_en) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_lo = ptr_q[MEM_AW-1:0];

  // R4: one step per driven nibble, modulo 2^PTR_W
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !cap_en) |=> ptr_q == $past(ptr_q) + 1'b1);

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !cap_en) |=> $stable(ptr_q));

endmodule

// File: rtl/nbus_read_path.sv
module nbus_read_path
  import nbus_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state_q,
  input  logic              load_now,
  input  logic [MEM_AW-1:0] ptr_lo,
  input  logic [NIB_W-1:0]  ram_rdata,
  output logic              ram_rd_en,
  output logic [MEM_AW-1:0] ram_addr,
  output logic              drive_en,
  output logic [NIB_W-1:0]  nib_out
);

  logic in_read;
  logic in_dummy;

  assign in_read   = (state_q == ST_READ);
  assign in_dummy  = (state_q == ST_DUMMY);
  assign drive_en  = in_read && !load_now;
  assign ram_rd_en = (in_read || in_dummy) && !load_now;
  // the dummy cycle fetches the pointer itself, each data cycle fetches the next one
  assign ram_addr  = in_read ? ptr_lo + 1'b1 : ptr_lo;
  assign nib_out   = drive_en ? ram_rdata : '0;

  // R9: every driven nibble was requested one cycle before
  p_data_prefetched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> $past(ram_rd_en));

  // R3: the bus is quiet when not driving
  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> nib_out == '0);

endmodule

// File: rtl/nbus_mem_ctrl.sv
module nbus_mem_ctrl
  import nbus_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 5,
  parameter int WORD_NIBS = 16,
  parameter int MEM_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_cmd,
  input  logic [NIB_W-1:0]  bus_nib_in,
  output logic [NIB_W-1:0]  bus_nib_out,
  output logic              bus_drive_en,
  output logic              ram_rd_en,
  output logic [MEM_AW-1:0] ram_addr,
  input  logic [NIB_W-1:0]  ram_rdata
);

  localparam int CNT_MAX = (ADDR_NIBS > WORD_NIBS) ? ADDR_NIBS : WORD_NIBS;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int N_PTR   = 2;

  ctl_state_e       state_q;
  ptr_sel_e         sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load_now;
  logic             cap_en;
  logic             drive_en;
  logic [MEM_AW-1:0] ptr_lo_w [N_PTR];
  logic [MEM_AW-1:0] cur_lo;

  nbus_cmd_fsm #(
    .ADDR_NIBS (ADDR_NIBS),
    .WORD_NIBS (WORD_NIBS),
    .CNT_W     (CNT_W)
  ) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (bus_cmd_e'(bus_cmd)),
    .state_q  (state_q),
    .sel_q    (sel_q),
    .cnt_q    (cnt_q),
    .load_now (load_now)
  );

  assign cap_en = (state_q == ST_ADDR) && !load_now;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    nbus_ptr_reg #(
      .NIB_W     (NIB_W),
      .ADDR_NIBS (ADDR_NIBS),
      .IDX_W     (CNT_W),
      .MEM_AW    (MEM_AW)
    ) ptr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en && (sel_q == ptr_sel_e'(g))),
      .cap_idx (cnt_q),
      .cap_nib (bus_nib_in),
      .inc_en  (drive_en && (sel_q == ptr_sel_e'(g))),
      .ptr_lo  (ptr_lo_w[g])
    );
  end

  assign cur_lo = ptr_lo_w[sel_q];

  nbus_read_path #(
    .NIB_W  (NIB_W),
    .MEM_AW (MEM_AW)
  ) rd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .load_now  (load_now),
    .ptr_lo    (cur_lo),
    .ram_rdata (ram_rdata),
    .ram_rd_en (ram_rd_en),
    .ram_addr  (ram_addr),
    .drive_en  (drive_en),
    .nib_out   (bus_nib_out)
  );

  assign bus_drive_en = drive_en;

  // R7: no drive and no memory read in a command cycle
  p_cmd_cycle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |-> !bus_drive_en && !ram_rd_en);

  // R2: a dummy cycle never drives but always reads memory
  p_dummy_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DUMMY && !load_now) |-> !bus_drive_en && ram_rd_en);

endmodule

// File: tb/nbus_mem_ctrl_tb_top.sv
module nbus_mem_ctrl_tb_top;

  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_LDP  = 2'b01;
  localparam logic [1:0] C_LPC  = 2'b10;
  localparam logic [1:0] C_RSV  = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_cmd = C_NONE;
  logic [3:0] bus_nib_in = '0;
  logic [3:0] bus_nib_out;
  logic       bus_drive_en;
  logic       ram_rd_en;
  logic [7:0] ram_addr;
  logic [3:0] ram_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  nbus_mem_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cmd      (bus_cmd),
    .bus_nib_in   (bus_nib_in),
    .bus_nib_out  (bus_nib_out),
    .bus_drive_en (bus_drive_en),
    .ram_rd_en    (ram_rd_en),
    .ram_addr     (ram_addr),
    .ram_rdata    (ram_rdata)
  );

  function automatic logic [3:0] mem_val(logic [7:0] a);
    return 4'(a[3:0] + 3 * a[7:4] + 5);
  endfunction

  // synchronous memory model, one cycle of read latency
  always_ff @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= mem_val(ram_addr);
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic [1:0] c, logic [3:0] n);
    @(negedge clk);
    bus_cmd    = c;
    bus_nib_in = n;
    #1;
  endtask

  task automatic load_addr(logic [1:0] c, logic [19:0] a, int rsvd_at, string req);
    cyc(c, 4'h0);
    check(bus_drive_en == 1'b0, req, "drive in load cycle", bus_drive_en, 0);
    check(ram_rd_en == 1'b0, req, "ram read in load cycle", ram_rd_en, 0);
    for (int i = 0; i < 5; i++) begin
      cyc((i == rsvd_at) ? C_RSV : C_NONE, a[4*i +: 4]);
      check(bus_drive_en == 1'b0, "R3", "drive in address cycle", bus_drive_en, 0);
    end
  endtask

  task automatic dummy_cycle(logic [19:0] a);
    cyc(C_NONE, 4'h0);
    check(bus_drive_en == 1'b0, "R2", "drive in dummy cycle", bus_drive_en, 0);
    check(ram_rd_en && ram_addr == a[7:0], "R9", "dummy fetch address",
          ram_addr, a[7:0]);
  endtask

  task automatic read_nibs(logic [19:0] a, int start, int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [19:0] p;
      p = a + 20'(start + i);
      cyc(C_NONE, 4'h0);
      check(bus_drive_en == 1'b1, req, "drive in data cycle", bus_drive_en, 1);
      check(bus_nib_out == mem_val(p[7:0]), req, "data nibble",
            bus_nib_out, mem_val(p[7:0]));
    end
  endtask

  task automatic expect_quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      cyc(C_NONE, 4'h0);
      check(!bus_drive_en && bus_nib_out == 4'h0 && !ram_rd_en, req,
            "bus quiet", {bus_drive_en, ram_rd_en, bus_nib_out}, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    check(!bus_drive_en && !ram_rd_en && bus_nib_out == 4'h0, "R10",
          "outputs in reset", {bus_drive_en, ram_rd_en, bus_nib_out}, 0);
    expect_quiet(2, "R10");
  endtask

  task automatic t_dp_word();
    load_addr(C_LDP, 20'h12345, -1, "R1");
    dummy_cycle(20'h12345);
    read_nibs(20'h12345, 0, 16, "R4");
    expect_quiet(3, "R5");
  endtask

  task automatic t_pc_stream_wrap();
    load_addr(C_LPC, 20'hFFFFC, -1, "R1");
    dummy_cycle(20'hFFFFC);
    read_nibs(20'hFFFFC, 0, 24, "R6");
  endtask

  task automatic t_abort_in_read();
    load_addr(C_LDP, 20'h00A10, -1, "R1");
    dummy_cycle(20'h00A10);
    read_nibs(20'h00A10, 0, 3, "R4");
    load_addr(C_LPC, 20'h0BEEF, -1, "R7");
    dummy_cycle(20'h0BEEF);
    read_nibs(20'h0BEEF, 0, 5, "R7");
  endtask

  task automatic t_abort_in_addr_and_dummy();
    cyc(C_LDP, 4'h0);
    cyc(C_NONE, 4'hA);
    cyc(C_NONE, 4'h7);
    load_addr(C_LDP, 20'h55377, -1, "R7");
    dummy_cycle(20'h55377);
    read_nibs(20'h55377, 0, 3, "R7");
    load_addr(C_LPC, 20'h300C8, -1, "R1");
    load_addr(C_LDP, 20'h9A0E2, -1, "R7");
    dummy_cycle(20'h9A0E2);
    read_nibs(20'h9A0E2, 0, 16, "R7");
    expect_quiet(1, "R5");
  endtask

  task automatic t_reserved();
    load_addr(C_LDP, 20'h4C2D1, 2, "R8");
    dummy_cycle(20'h4C2D1);
    read_nibs(20'h4C2D1, 0, 2, "R8");
    cyc(C_RSV, 4'h0);
    check(bus_drive_en == 1'b1, "R8", "drive with reserved code", bus_drive_en, 1);
    check(bus_nib_out == mem_val(8'hD3), "R8", "data with reserved code",
          bus_nib_out, mem_val(8'hD3));
    read_nibs(20'h4C2D1, 3, 13, "R8");
    cyc(C_RSV, 4'h0);
    check(!bus_drive_en && !ram_rd_en, "R8", "reserved code in idle",
          {bus_drive_en, ram_rd_en}, 0);
    expect_quiet(2, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    expect_quiet(2, "R10");
    t_dp_word();
    t_pc_stream_wrap();
    t_abort_in_read();
    t_abort_in_addr_and_dummy();
    t_reserved();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule